// File: doc/BRIEF.md
# SPI command transaction engine

This block is the host side of a command exchange with a wireless-module style SPI slave. A request names an opcode, an address, a 32-bit argument (a transfer size or a write word) and two flags: one asks for clockless register access and one enables the CRC trailer. The engine builds the header for that opcode and sends it one byte at a time through a simple full-duplex byte shifter. When CRC is enabled it appends a CRC7 byte. It then clocks zero bytes while it watches the reply for the echoed opcode and a zero state byte, and it reports ok or fail with a done pulse. Read data capture and block payload streaming are handled by other blocks.

Requests arrive on a valid/ready handshake. `req_ready` is high only while the engine is idle. A request is taken in a cycle where `req_valid` and `req_ready` are both high, and all request fields must hold steady while `req_valid` is high and `req_ready` is low. After acceptance `req_ready` stays low until the cycle in which `done` pulses. A register mode lets the engine choose the opcode itself from the address.

The shifter side is a plain request/acknowledge pair. `sh_req` is held high with a byte on `sh_tx_byte`. The shifter answers with a one-cycle `sh_ack` that carries the byte received in the same exchange on `sh_rx_byte`.

Top module: `spi_cmd_engine`

## Requirements
- R1: `req_ready` is high exactly when no transaction is in flight, and a request is accepted on a cycle with `req_valid` and `req_ready` both high.
- R2: The header length without CRC is 4 bytes for single read (0xCA), internal read (0xC4), terminate (0xC5), repeat (0xC6) and reset (0xCF). It is 6 bytes for DMA write/read (0xC1/0xC2), 7 bytes for extended DMA write/read (0xC7/0xC8) and internal write (0xC3), and 8 bytes for single write (0xC9).
- R3: Header contents always start with the opcode:
  - Single and DMA opcodes send a 24-bit address, most significant byte first.
  - DMA sends the low 16 bits of the argument as the size; extended DMA sends the low 24 bits.
  - Write opcodes send the 32-bit argument most significant byte first.
  - Internal opcodes send a 16-bit address, and bit 7 of the first address byte is forced to 1 when clockless is requested. Internal read pads with one 0x00 byte.
  - Terminate and repeat send three 0x00 bytes; reset sends three 0xFF bytes.
- R4: With CRC enabled, one extra byte follows the header. Bits 7:1 hold a CRC7 (polynomial x^7+x^3+1, register seeded to 0x7F, header bytes fed most significant bit first) and bit 0 is 0.
- R5: With CRC disabled, no CRC byte is sent.
- R6: After the header (and CRC), 0x00 bytes are sent: 6 for reset, terminate and repeat; 10 for single and internal reads, plus 2 more with CRC enabled; 5 for all other opcodes.
- R7: For reset, terminate and repeat, the first received byte after the header/CRC is ignored. Bytes received during the header, and bytes received after the state byte, never affect the result.
- R8: The reply byte at the echo position must equal the opcode, and the byte after it must be 0x00. Otherwise `ok` is 0 at `done`. The frame still runs to its full length.
- R9: An opcode outside the list is accepted and answered with `done` high and `ok` low two cycles after acceptance. `cs` and `sh_req` never rise for it.
- R10: With `req_reg_mode` high, an address below 0x30 issues internal write or read (chosen by `req_reg_write`) with clockless set. Any other address issues single write or read. `req_opcode` and `req_clockless` are then ignored.
- R11: `cs` is high from the first byte until the last byte is acknowledged. `done` is a one-cycle pulse in the cycle after the last acknowledge, with `cs` already low.
- R12: While `sh_req` is high and no `sh_ack` arrives, `sh_tx_byte` holds its value. Each `sh_ack` advances exactly one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_opcode | input | 8 | Opcode (ignored in register mode) |
| req_addr | input | 24 | Target address |
| req_arg | input | 32 | Transfer size or write word |
| req_clockless | input | 1 | Clockless flag for internal opcodes |
| req_crc_en | input | 1 | Append CRC7 byte and CRC-sized padding |
| req_reg_mode | input | 1 | Let the engine pick the opcode from the address |
| req_reg_write | input | 1 | Register mode direction, 1 = write |
| sh_req | output | 1 | Byte exchange requested |
| sh_tx_byte | output | 8 | Byte to transmit |
| sh_ack | input | 1 | Exchange complete, one cycle |
| sh_rx_byte | input | 8 | Byte received in the acknowledged exchange |
| cs | output | 1 | Chip select, active high |
| done | output | 1 | Transaction finished, one cycle |
| ok | output | 1 | Result, valid with done |

## Verification
The bench sweeps every listed opcode against both CRC settings and both clockless settings. This separates the length and field-order rules per opcode, the clockless bit that only internal opcodes carry, and the presence of the trailer and the extra read padding. A clean reply, a corrupted echo and a non-zero state byte are applied to each opcode, which tells a correct position of the check from one off by a byte. Junk placed in the skip slot, the header slots and the dummy slots must leave the result ok, so ignored bytes are shown to be ignored. Illegal opcodes and register-mode addresses on each side of 0x30 finish the sweep.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] OP_DMA_WR  = 8'hC1;
  localparam logic [7:0] OP_DMA_RD  = 8'hC2;
  localparam logic [7:0] OP_INT_WR  = 8'hC3;
  localparam logic [7:0] OP_INT_RD  = 8'hC4;
  localparam logic [7:0] OP_TERM    = 8'hC5;
  localparam logic [7:0] OP_REPEAT  = 8'hC6;
  localparam logic [7:0] OP_XDMA_WR = 8'hC7;
  localparam logic [7:0] OP_XDMA_RD = 8'hC8;
  localparam logic [7:0] OP_WORD_WR = 8'hC9;
  localparam logic [7:0] OP_WORD_RD = 8'hCA;
  localparam logic [7:0] OP_RESET   = 8'hCF;

  localparam int HDR_MAX     = 8;
  localparam int HDR_IDX_W   = $clog2(HDR_MAX);
  localparam int LEN_W       = $clog2(HDR_MAX + 1);
  localparam int PAD_MAX     = 12;
  localparam int FRAME_MAX   = HDR_MAX + 1 + PAD_MAX;
  localparam int FRAME_IDX_W = $clog2(FRAME_MAX + 1);
  localparam logic [6:0] CRC_SEED = 7'h7F;

  typedef enum logic [1:0] {
    KIND_PLAIN = 2'd0,
    KIND_CTRL  = 2'd1,
    KIND_READ  = 2'd2
  } reply_kind_e;

  typedef logic [HDR_MAX-1:0][7:0] hdr_bytes_t;

  function automatic logic [6:0] crc7_feed(input logic [6:0] cur, input logic [7:0] din);
    logic [6:0] c;
    logic       fb;
    c = cur;
    for (int b = 7; b >= 0; b--) begin
      fb = c[6] ^ din[b];
      c  = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction

  function automatic logic [FRAME_IDX_W-1:0] pad_count(input reply_kind_e k, input logic crc_on);
    case (k)
      KIND_CTRL: return FRAME_IDX_W'(6);
      KIND_READ: return crc_on ? FRAME_IDX_W'(12) : FRAME_IDX_W'(10);
      default:   return FRAME_IDX_W'(5);
    endcase
  endfunction

endpackage

// File: rtl/spi_cmd_decode.sv
module spi_cmd_decode
  import spi_cmd_pkg::*;
#(
  parameter int REG_LIMIT = 'h30
) (
  input  logic [7:0]        op_in,
  input  logic [23:0]       addr_in,
  input  logic [31:0]       arg_in,
  input  logic              clockless_in,
  input  logic              reg_mode,
  input  logic              reg_write,
  output logic              legal,
  output logic [7:0]        op_eff,
  output hdr_bytes_t        hdr,
  output logic [LEN_W-1:0]  hdr_len,
  output reply_kind_e       kind
);

  logic       low_reg;
  logic       cl_eff;
  logic [7:0] ia_hi;

  assign low_reg = (addr_in < 24'(REG_LIMIT));

  always_comb begin
    if (reg_mode) begin
      op_eff = low_reg ? (reg_write ? OP_INT_WR : OP_INT_RD)
                       : (reg_write ? OP_WORD_WR : OP_WORD_RD);
      cl_eff = low_reg;
    end else begin
      op_eff = op_in;
      cl_eff = clockless_in;
    end
  end

  assign ia_hi = {addr_in[15] | cl_eff, addr_in[14:8]};

  always_comb begin
    hdr     = '0;
    hdr[0]  = op_eff;
    hdr_len = LEN_W'(4);
    kind    = KIND_PLAIN;
    legal   = 1'b1;
    case (op_eff)
      OP_DMA_WR, OP_DMA_RD: begin
        hdr[1] = addr_in[23:16]; hdr[2] = addr_in[15:8]; hdr[3] = addr_in[7:0];
        hdr[4] = arg_in[15:8];   hdr[5] = arg_in[7:0];
        hdr_len = LEN_W'(6);
      end
      OP_XDMA_WR, OP_XDMA_RD: begin
        hdr[1] = addr_in[23:16]; hdr[2] = addr_in[15:8]; hdr[3] = addr_in[7:0];
        hdr[4] = arg_in[23:16];  hdr[5] = arg_in[15:8];  hdr[6] = arg_in[7:0];
        hdr_len = LEN_W'(7);
      end
      OP_INT_WR: begin
        hdr[1] = ia_hi;          hdr[2] = addr_in[7:0];
        hdr[3] = arg_in[31:24];  hdr[4] = arg_in[23:16];
        hdr[5] = arg_in[15:8];   hdr[6] = arg_in[7:0];
        hdr_len = LEN_W'(7);
      end
      OP_INT_RD: begin
        hdr[1] = ia_hi; hdr[2] = addr_in[7:0]; hdr[3] = 8'h00;
        kind   = KIND_READ;
      end
      OP_TERM, OP_REPEAT: begin
        kind = KIND_CTRL;
      end
      OP_RESET: begin
        hdr[1] = 8'hFF; hdr[2] = 8'hFF; hdr[3] = 8'hFF;
        kind   = KIND_CTRL;
      end
      OP_WORD_WR: begin
        hdr[1] = addr_in[23:16]; hdr[2] = addr_in[15:8]; hdr[3] = addr_in[7:0];
        hdr[4] = arg_in[31:24];  hdr[5] = arg_in[23:16];
        hdr[6] = arg_in[15:8];   hdr[7] = arg_in[7:0];
        hdr_len = LEN_W'(8);
      end
      OP_WORD_RD: begin
        hdr[1] = addr_in[23:16]; hdr[2] = addr_in[15:8]; hdr[3] = addr_in[7:0];
        kind   = KIND_READ;
      end
      default: begin
        legal = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (legal) begin
      assert_len_range_R2: assert (hdr_len >= LEN_W'(4) && hdr_len <= LEN_W'(HDR_MAX))
        else $error("header length out of range");
    end
  end

endmodule

// File: rtl/spi_cmd_crc7.sv
module spi_cmd_crc7
  import spi_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [6:0] crc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc <= CRC_SEED;
    else if (clear)  crc <= CRC_SEED;
    else if (upd)    crc <= crc7_feed(crc, din);
  end

endmodule

// File: rtl/spi_cmd_reply_chk.sv
module spi_cmd_reply_chk #(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             byte_done,
  input  logic             in_pad,
  input  logic [IDX_W-1:0] pad_pos,
  input  logic             skip_first,
  input  logic [7:0]       expect_op,
  input  logic [7:0]       rx_byte,
  output logic             mismatch,
  output logic             fail_q
);

  logic [IDX_W-1:0] echo_pos;
  logic [IDX_W-1:0] state_pos;

  assign echo_pos  = skip_first ? IDX_W'(1) : IDX_W'(0);
  assign state_pos = echo_pos + IDX_W'(1);

  always_comb begin
    mismatch = 1'b0;
    if (byte_done && in_pad) begin
      if (pad_pos == echo_pos && rx_byte != expect_op) mismatch = 1'b1;
      if (pad_pos == state_pos && rx_byte != 8'h00)    mismatch = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        fail_q <= 1'b0;
    else if (clear)    fail_q <= 1'b0;
    else if (mismatch) fail_q <= 1'b1;
  end

  assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !clear) |=> fail_q)
    else $error("reply failure flag dropped inside a frame");

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int REG_LIMIT = 'h30
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_opcode,
  input  logic [23:0] req_addr,
  input  logic [31:0] req_arg,
  input  logic        req_clockless,
  input  logic        req_crc_en,
  input  logic        req_reg_mode,
  input  logic        req_reg_write,
  output logic        sh_req,
  output logic [7:0]  sh_tx_byte,
  input  logic        sh_ack,
  input  logic [7:0]  sh_rx_byte,
  output logic        cs,
  output logic        done,
  output logic        ok
);

  localparam int IDX_W = FRAME_IDX_W;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_REJECT} state_e;

  state_e            state;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  total_q;
  hdr_bytes_t        hdr_q;
  logic [LEN_W-1:0]  body_q;
  logic              crc_on_q;
  logic [7:0]        op_q;
  reply_kind_e       kind_q;
  logic              cs_q, done_q, ok_q;

  logic              dec_legal;
  logic [7:0]        dec_op;
  hdr_bytes_t        dec_hdr;
  logic [LEN_W-1:0]  dec_len;
  reply_kind_e       dec_kind;

  logic              start;
  logic              byte_done;
  logic              last_byte;
  logic [IDX_W-1:0]  body_w, hlen;
  logic              in_body, in_pad;
  logic [IDX_W-1:0]  pad_pos;
  logic [6:0]        crc_val;
  logic              chk_mismatch, chk_fail;

  spi_cmd_decode #(.REG_LIMIT(REG_LIMIT)) u_decode (
    .op_in        (req_opcode),
    .addr_in      (req_addr),
    .arg_in       (req_arg),
    .clockless_in (req_clockless),
    .reg_mode     (req_reg_mode),
    .reg_write    (req_reg_write),
    .legal        (dec_legal),
    .op_eff       (dec_op),
    .hdr          (dec_hdr),
    .hdr_len      (dec_len),
    .kind         (dec_kind)
  );

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;
  assign sh_req    = (state == ST_XFER);
  assign byte_done = sh_req && sh_ack;
  assign last_byte = (idx == total_q - IDX_W'(1));

  assign body_w  = IDX_W'(body_q);
  assign hlen    = body_w + IDX_W'(crc_on_q);
  assign in_body = (idx < body_w);
  assign in_pad  = (idx >= hlen);
  assign pad_pos = idx - hlen;

  always_comb begin
    if (in_body)                          sh_tx_byte = hdr_q[idx[HDR_IDX_W-1:0]];
    else if (crc_on_q && idx == body_w)   sh_tx_byte = {crc_val, 1'b0};
    else                                  sh_tx_byte = 8'h00;
  end

  spi_cmd_crc7 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start),
    .upd   (byte_done && in_body),
    .din   (sh_tx_byte),
    .crc   (crc_val)
  );

  spi_cmd_reply_chk #(.IDX_W(IDX_W)) u_reply (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start),
    .byte_done  (byte_done),
    .in_pad     (in_pad),
    .pad_pos    (pad_pos),
    .skip_first (kind_q == KIND_CTRL),
    .expect_op  (op_q),
    .rx_byte    (sh_rx_byte),
    .mismatch   (chk_mismatch),
    .fail_q     (chk_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      total_q  <= '0;
      hdr_q    <= '0;
      body_q   <= '0;
      crc_on_q <= 1'b0;
      op_q     <= 8'h00;
      kind_q   <= KIND_PLAIN;
      cs_q     <= 1'b0;
      done_q   <= 1'b0;
      ok_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            idx      <= '0;
            hdr_q    <= dec_hdr;
            body_q   <= dec_len;
            crc_on_q <= req_crc_en;
            op_q     <= dec_op;
            kind_q   <= dec_kind;
            total_q  <= IDX_W'(dec_len) + IDX_W'(req_crc_en) + pad_count(dec_kind, req_crc_en);
            ok_q     <= 1'b0;
            if (dec_legal) begin
              state <= ST_XFER;
              cs_q  <= 1'b1;
            end else begin
              state <= ST_REJECT;
            end
          end
        end
        ST_XFER: begin
          if (sh_ack) begin
            idx <= idx + IDX_W'(1);
            if (last_byte) begin
              state  <= ST_IDLE;
              cs_q   <= 1'b0;
              done_q <= 1'b1;
              ok_q   <= !(chk_fail || chk_mismatch);
            end
          end
        end
        default: begin
          state  <= ST_IDLE;
          done_q <= 1'b1;
          ok_q   <= 1'b0;
        end
      endcase
    end
  end

  assign cs   = cs_q;
  assign done = done_q;
  assign ok   = ok_q;

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs |-> !req_ready)
    else $error("ready while a frame is in flight");

  assert_reject_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !dec_legal) |=> (!cs && !sh_req && !done) ##1 (done && !ok && !cs))
    else $error("illegal opcode not rejected silently");

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done)
    else $error("done longer than one cycle");

  assert_done_after_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ok) |-> ($past(sh_ack) && !cs))
    else $error("ok result without a final byte exchange");

  assert_tx_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_req && !sh_ack) |=> (sh_req && $stable(sh_tx_byte)))
    else $error("byte changed before acknowledge");

endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [7:0]  req_opcode = 8'h00;
  logic [23:0] req_addr = 24'h0;
  logic [31:0] req_arg = 32'h0;
  logic        req_clockless = 1'b0;
  logic        req_crc_en = 1'b0;
  logic        req_reg_mode = 1'b0;
  logic        req_reg_write = 1'b0;
  logic        sh_req;
  logic [7:0]  sh_tx_byte;
  logic        sh_ack = 1'b0;
  logic [7:0]  sh_rx_byte = 8'h00;
  logic        cs;
  logic        done;
  logic        ok;

  always #2.5 clk = ~clk;

  spi_cmd_engine u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_opcode(req_opcode), .req_addr(req_addr), .req_arg(req_arg),
    .req_clockless(req_clockless), .req_crc_en(req_crc_en),
    .req_reg_mode(req_reg_mode), .req_reg_write(req_reg_write),
    .sh_req(sh_req), .sh_tx_byte(sh_tx_byte), .sh_ack(sh_ack),
    .sh_rx_byte(sh_rx_byte), .cs(cs), .done(done), .ok(ok)
  );

  int checks = 0;
  int errors = 0;
  int nb = 0;
  int unstable = 0;
  int cs_drop = 0;
  bit finished = 0;
  logic [7:0] exp_tx [0:31];
  logic [7:0] got_tx [0:31];
  logic [7:0] rx_script [0:31];

  task automatic check(input bit cond, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // shifter model: holds each byte 0..2 extra cycles, then acknowledges
  initial begin
    logic [7:0] first;
    forever begin
      @(negedge clk);
      if (sh_req) begin
        first = sh_tx_byte;
        repeat (nb % 3) begin
          @(negedge clk);
          if (!cs) cs_drop++;
        end
        if (sh_tx_byte !== first) unstable++;
        if (!cs) cs_drop++;
        got_tx[nb] = sh_tx_byte;
        sh_rx_byte = rx_script[nb];
        sh_ack = 1'b1;
        nb++;
        @(negedge clk);
        sh_ack = 1'b0;
      end
    end
  end

  function automatic logic [7:0] crc_step(input logic [7:0] r, input logic [7:0] d);
    logic [7:0] x;
    x = r;
    for (int i = 7; i >= 0; i--) begin
      if (x[7] ^ d[i]) x = (x << 1) ^ 8'h12;
      else             x = x << 1;
    end
    return x;
  endfunction

  // err: 0 clean, 1 bad echo, 2 bad state, 3 junk in ignored slots
  task automatic run(input logic [7:0] op, input logic [23:0] addr, input logic [31:0] arg,
                     input logic cl, input logic crc, input logic rm, input logic rw,
                     input int err);
    logic [7:0] eop;
    logic       ecl;
    logic [7:0] body [0:7];
    int         n, total, pad, skip, cyc, pos;
    bit         legal, exp_ok, ctrl, mism;
    logic [7:0] r;
    logic [7:0] ia;

    eop = op; ecl = cl;
    if (rm) begin
      ecl = (addr < 24'h30);
      eop = ecl ? (rw ? 8'hC3 : 8'hC4) : (rw ? 8'hC9 : 8'hCA);
    end
    ia = addr[15:8] | (ecl ? 8'h80 : 8'h00);
    legal = 1; ctrl = 0; n = 4; pad = 5;
    for (int i = 0; i < 8; i++) body[i] = 8'h00;
    body[0] = eop;
    case (eop)
      8'hC1, 8'hC2: begin body[1]=addr[23:16]; body[2]=addr[15:8]; body[3]=addr[7:0];
                          body[4]=arg[15:8]; body[5]=arg[7:0]; n=6; end
      8'hC7, 8'hC8: begin body[1]=addr[23:16]; body[2]=addr[15:8]; body[3]=addr[7:0];
                          body[4]=arg[23:16]; body[5]=arg[15:8]; body[6]=arg[7:0]; n=7; end
      8'hC3: begin body[1]=ia; body[2]=addr[7:0]; body[3]=arg[31:24]; body[4]=arg[23:16];
                   body[5]=arg[15:8]; body[6]=arg[7:0]; n=7; end
      8'hC4: begin body[1]=ia; body[2]=addr[7:0]; pad = crc ? 12 : 10; end
      8'hC5, 8'hC6: begin ctrl=1; pad=6; end
      8'hCF: begin body[1]=8'hFF; body[2]=8'hFF; body[3]=8'hFF; ctrl=1; pad=6; end
      8'hC9: begin body[1]=addr[23:16]; body[2]=addr[15:8]; body[3]=addr[7:0];
                   body[4]=arg[31:24]; body[5]=arg[23:16]; body[6]=arg[15:8]; body[7]=arg[7:0]; n=8; end
      8'hCA: begin body[1]=addr[23:16]; body[2]=addr[15:8]; body[3]=addr[7:0];
                   pad = crc ? 12 : 10; end
      default: legal = 0;
    endcase
    total = n + (crc ? 1 : 0) + pad;
    for (int i = 0; i < 32; i++) begin exp_tx[i] = 8'h00; got_tx[i] = 8'h00; rx_script[i] = 8'hA5; end
    r = 8'hFE;
    for (int i = 0; i < n; i++) begin exp_tx[i] = body[i]; r = crc_step(r, body[i]); end
    if (crc) exp_tx[n] = {r[7:1], 1'b0};
    skip = ctrl ? 1 : 0;
    for (int k = 0; k < pad; k++) begin
      pos = n + (crc ? 1 : 0) + k;
      if (k < skip)            rx_script[pos] = (err == 3) ? eop : 8'h3C;
      else if (k == skip)      rx_script[pos] = (err == 1) ? (eop ^ 8'h01) : eop;
      else if (k == skip + 1)  rx_script[pos] = (err == 2) ? 8'h01 : 8'h00;
      else                     rx_script[pos] = (err == 3) ? 8'hFF : 8'h00;
    end
    if (err == 3) for (int i = 0; i < n; i++) rx_script[i] = 8'hFF;
    exp_ok = legal && (err == 0 || err == 3);

    nb = 0; unstable = 0; cs_drop = 0;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_opcode = op; req_addr = addr; req_arg = arg; req_clockless = cl;
    req_crc_en = crc; req_reg_mode = rm; req_reg_write = rw; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (legal) check(!req_ready, "R1", "ready while busy", req_ready, 0);
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    check(done === 1'b1, "R11", "done seen", done, 1);
    check(ok === exp_ok, (err == 3) ? "R7" : (err != 0 ? "R8" : (rm ? "R10" : "R8")),
          "ok result", ok, exp_ok);
    check(cs === 1'b0, "R11", "cs low at done", cs, 0);
    if (!legal) begin
      check(nb == 0, "R9", "bytes sent for illegal opcode", nb, 0);
      check(cyc == 1, "R9", "reject latency", cyc, 1);
    end else begin
      check(nb == total, crc ? "R6" : "R5", "frame length", nb, total);
      mism = 0;
      for (int i = 0; i < total; i++) begin
        if (got_tx[i] !== exp_tx[i] && !mism) begin
          mism = 1;
          check(0, (i < n) ? (rm ? "R10" : "R3") : ((crc && i == n) ? "R4" : "R6"),
                "frame byte", got_tx[i], exp_tx[i]);
        end
      end
      if (!mism) check(1, "R2", "frame bytes", 0, 0);
      check(unstable == 0 && cs_drop == 0, "R12", "byte held until ack with cs up", unstable + cs_drop, 0);
    end
    @(negedge clk);
    check(!done, "R11", "done one cycle", done, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] ops [0:10];
    logic [7:0] bad [0:6];
    ops = '{8'hC1, 8'hC2, 8'hC3, 8'hC4, 8'hC5, 8'hC6, 8'hC7, 8'hC8, 8'hC9, 8'hCA, 8'hCF};
    bad = '{8'h00, 8'hC0, 8'hCB, 8'hCC, 8'hCD, 8'hD0, 8'hFF};
    repeat (3) @(negedge clk);
    check(req_ready === 1'b1, "R1", "ready after reset", req_ready, 1);
    check(cs === 1'b0 && sh_req === 1'b0, "R11", "cs idle after reset", cs, 0);
    check(done === 1'b0, "R11", "done low after reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int o = 0; o < 11; o++)
      for (int c = 0; c < 2; c++)
        for (int l = 0; l < 2; l++)
          run(ops[o], 24'h12_3456 ^ 24'(o * 24'h01_1111) ^ 24'(l * 24'h00_8000),
              32'hA1B2_C3D4 + 32'(o * 7 + c), l[0], c[0], 1'b0, 1'b0, 0);

    for (int o = 0; o < 11; o++) begin
      run(ops[o], 24'h00_0A0B, 32'h0102_0304, 1'b0, 1'b1, 1'b0, 1'b0, 1);
      run(ops[o], 24'h00_0A0B, 32'h0102_0304, 1'b0, 1'b0, 1'b0, 1'b0, 2);
      run(ops[o], 24'h00_0A0B, 32'h0102_0304, 1'b1, 1'b1, 1'b0, 1'b0, 3);
    end

    for (int b = 0; b < 7; b++)
      run(bad[b], 24'h00_1000, 32'h0, 1'b0, b[0], 1'b0, 1'b0, 0);

    run(8'h00, 24'h00_002F, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 1'b1, 0);
    run(8'h00, 24'h00_0030, 32'hDEAD_BEEF, 1'b1, 1'b1, 1'b1, 1'b1, 0);
    run(8'hC5, 24'h00_0000, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0, 0);
    run(8'hC1, 24'h00_1000, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule